// File: doc/BRIEF.md
# Self-Clearing Counter Clear Register

This block holds a small host-visible control register in which every bit stands for one counter in a monitoring device. Writing a 1 to a bit asks for that counter to be zeroed. The logic issues a one-cycle clear strobe to the target and then drops the request bit on its own, so the host never has to write the bit back to 0.

Two targets are elapsed-time counters: one for discharge time and one for charge time. Each advances once per programmable number of timebase ticks while its run input is high. Each raises a status flag when it wraps. Zeroing a time counter also drops its flag and restores its period to the default of 28800 timebase ticks. At a 32.768 kHz timebase that is one count per 0.8789 s. The remaining targets are plain event counters.

The host reaches all state through a simple write port and a combinational read port. The address map is: 0 clear register, 1 discharge period, 2 charge period, 3 flags (read-only), 4 and up counter values (read-only).

Top module: `ccc_top`

## Requirements
- R1: Writing address 0 sets the pending bit for every data bit written as 1. Bit 0 is the discharge counter, bit 1 the charge counter, bits 2 and up are event counters 0, 1, .... Pending bits read back as 1 at address 0. Bits written as 0 change neither a pending bit nor any counter.
- R2: A pending bit produces a one-cycle pulse on `clr_strobe` in the cycle after it becomes visible. The pending bit reads 0 from the cycle after the pulse, unless it is written again.
- R3: Several bits written as 1 in one write are all serviced in the same cycles. Counters whose bits were 0 are left untouched.
- R4: Clearing the discharge counter also clears flag bit 0 (address 3) and restores the discharge period (address 1) to DEF_RATE. A period write in the strobe cycle loses to the clear.
- R5: Clearing the charge counter also clears flag bit 1 (address 3) and restores the charge period (address 2) to DEF_RATE.
- R6: A cleared counter reads 0 after the strobe cycle, even when an increment coincides with the strobe.
- R7: A time counter with period P advances once every P cycles in which both `tb_tick` and its `time_run` bit are high. P = 0 acts as 1. Incrementing from all ones wraps the counter to 0 and sets its flag.
- R8: Event counter k increments by one on each cycle with `evt_inc[k]` high. Its value reads at address 6 + k.
- R9: After reset all pending bits, strobes, counters and flags are 0, and both periods equal DEF_RATE (28800).
- R10: Writes to address 3 and to the counter addresses (4 and up) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| tb_tick | input | 1 | Timebase enable for the time counters |
| time_run | input | 2 | Run enables: bit 0 discharge, bit 1 charge |
| evt_inc | input | NUM_EVT | Increment requests for the event counters |
| clr_strobe | output | NUM_EVT+2 | One-cycle clear pulse per target |

## Verification
The clear strobe of a target can fall in the same cycle as that target's own update: an event increment, a time-counter tick, or a host write to its period register. The bench provokes each collision by holding the increment or tick active across the whole clear sequence, or by timing a period write to land on the strobe edge. It then reads the counter and period immediately after that edge. A zero counter, a cleared flag and the default period show that the clear took priority; a count of 1 or the written period means the collision was lost.

// File: rtl/ccc_pkg.sv
// Package: shared constants for the self-clearing clear register.
// Holds the fixed target ordering and the host address map.
package ccc_pkg;
    localparam int unsigned TIME_CTRS      = 2;   // discharge and charge time counters
    localparam int unsigned DSC_IDX        = 0;
    localparam int unsigned CHG_IDX        = 1;
    localparam int unsigned ADDR_CLR       = 0;
    localparam int unsigned ADDR_RATE_BASE = 1;   // period registers at 1 and 2
    localparam int unsigned ADDR_FLAGS     = 3;
    localparam int unsigned ADDR_CNT_BASE  = 4;   // counter values from 4 upward
endpackage

// File: rtl/ccc_req_bank.sv
// Module: ccc_req_bank
// Holds one pending bit per clear target and turns each into a single-cycle
// strobe. A request set by the host is pulsed on the next cycle and dropped
// on the cycle after. Assumes set_mask is only meaningful while set_en is high.
module ccc_req_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic [N-1:0] set_mask,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] strobe_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] strb_q;
    logic [N-1:0] new_req;

    // Select the request bits carried by the current host write.
    always_comb new_req = set_en ? set_mask : '0;

    // Advance pending bits and strobes; a strobed bit retires unless re-requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            strb_q <= '0;
        end else begin
            strb_q <= pend_q & ~strb_q;
            pend_q <= (pend_q & ~strb_q) | new_req;
        end
    end

    assign pend_o   = pend_q;
    assign strobe_o = strb_q;
endmodule

// File: rtl/ccc_time_counter.sv
// Module: ccc_time_counter
// Elapsed-time counter with a programmable period divider and a wrap flag.
// Counts once per RATE enabled timebase ticks (0 acts as 1). A clear zeroes
// count, divider and flag and restores the default period; the clear wins
// over a same-cycle tick or period write.
module ccc_time_counter #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned RATE_W   = 16,
    parameter int unsigned DEF_RATE = 28800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              run,
    input  logic              clr,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              flag_o,
    output logic [RATE_W-1:0] rate_o
);
    localparam logic [RATE_W-1:0] RATE_RST = RATE_W'(DEF_RATE);

    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] div_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              flag_q;
    logic              step;
    logic              fire;
    logic [RATE_W:0]   div_inc;

    // Decide whether this cycle consumes a tick and whether the period is complete.
    always_comb begin
        step    = tick_en && run;
        div_inc = {1'b0, div_q} + 1'b1;
        fire    = step && (div_inc >= {1'b0, rate_q});
    end

    // Update period, divider, count and wrap flag; clear takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rate_q <= RATE_RST;
            div_q  <= '0;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (rate_we) rate_q <= rate_wdata;
            if (fire) begin
                div_q <= '0;
                cnt_q <= cnt_q + 1'b1;
                if (&cnt_q) flag_q <= 1'b1;
            end else if (step) begin
                div_q <= div_inc[RATE_W-1:0];
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;
    assign rate_o = rate_q;
endmodule

// File: rtl/ccc_event_counter.sv
// Module: ccc_event_counter
// Plain event counter standing in for a counter or register pair.
// Increments on inc, wraps silently, and a clear wins over a same-cycle inc.
module ccc_event_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count events; reset or clear returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (inc)      cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/ccc_top.sv
// Module: ccc_top
// Self-clearing clear register with two elapsed-time counters and NUM_EVT
// event counters. Host writes address 0 to request clears; each request bit
// strobes its target once and returns to 0 by itself. Assumes
// NUM_EVT + 2 <= DATA_W, CNT_W <= DATA_W, RATE_W <= DATA_W and that ADDR_W
// reaches address 3 + NUM_EVT + 2.
module ccc_top
    import ccc_pkg::*;
#(
    parameter int unsigned NUM_EVT  = 2,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned RATE_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DEF_RATE = 28800
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         tb_tick,
    input  logic [TIME_CTRS-1:0]         time_run,
    input  logic [NUM_EVT-1:0]           evt_inc,
    output logic [NUM_EVT+TIME_CTRS-1:0] clr_strobe
);
    localparam int unsigned NUM_TGT = NUM_EVT + TIME_CTRS;

    logic [NUM_TGT-1:0]               pend;
    logic                             clr_set;
    logic [NUM_TGT-1:0][CNT_W-1:0]    cnt_all;
    logic [TIME_CTRS-1:0]             flag_all;
    logic [TIME_CTRS-1:0][RATE_W-1:0] rate_all;

    // Decode host writes aimed at the clear register.
    always_comb clr_set = wr_en && (wr_addr == ADDR_W'(ADDR_CLR));

    ccc_req_bank #(.N(NUM_TGT)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (clr_set),
        .set_mask (wr_data[NUM_TGT-1:0]),
        .pend_o   (pend),
        .strobe_o (clr_strobe)
    );

    for (genvar j = 0; j < TIME_CTRS; j++) begin : g_time
        logic rate_we;
        // Decode host writes aimed at this counter's period register.
        always_comb rate_we = wr_en && (wr_addr == ADDR_W'(ADDR_RATE_BASE + j));

        ccc_time_counter #(
            .CNT_W    (CNT_W),
            .RATE_W   (RATE_W),
            .DEF_RATE (DEF_RATE)
        ) u_tc (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_en    (tb_tick),
            .run        (time_run[j]),
            .clr        (clr_strobe[j]),
            .rate_we    (rate_we),
            .rate_wdata (wr_data[RATE_W-1:0]),
            .cnt_o      (cnt_all[j]),
            .flag_o     (flag_all[j]),
            .rate_o     (rate_all[j])
        );
    end

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
        ccc_event_counter #(.CNT_W(CNT_W)) u_ec (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt_inc[k]),
            .clr   (clr_strobe[TIME_CTRS+k]),
            .cnt_o (cnt_all[TIME_CTRS+k])
        );
    end

    // Return the register selected by rd_addr, zero-extended; unmapped reads give 0.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_CLR))   rd_data[NUM_TGT-1:0]   = pend;
        if (rd_addr == ADDR_W'(ADDR_FLAGS)) rd_data[TIME_CTRS-1:0] = flag_all;
        for (int j = 0; j < TIME_CTRS; j++) begin
            if (rd_addr == ADDR_W'(ADDR_RATE_BASE + j)) rd_data = DATA_W'(rate_all[j]);
        end
        for (int i = 0; i < NUM_TGT; i++) begin
            if (rd_addr == ADDR_W'(ADDR_CNT_BASE + i)) rd_data = DATA_W'(cnt_all[i]);
        end
    end
endmodule

// File: rtl/ccc_checker.sv
// Module: ccc_checker
// Property checker bound to ccc_top. Observes the request bank, strobes,
// counters, flags and periods and checks the clear protocol over time.
module ccc_checker #(
    parameter int unsigned NUM_TGT  = 4,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned RATE_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DEF_RATE = 28800
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [DATA_W-1:0]         wr_data,
    input logic [NUM_TGT-1:0]        clr_strobe,
    input logic [NUM_TGT-1:0]        pend,
    input logic [NUM_TGT-1:0][CNT_W-1:0] cnt_all,
    input logic [1:0]                flag_all,
    input logic [1:0][RATE_W-1:0]    rate_all
);
    logic clr_wr;
    // Flag host writes to the clear register.
    always_comb clr_wr = wr_en && (wr_addr == '0);

    for (genvar i = 0; i < NUM_TGT; i++) begin : g_bit
        // R2: a strobe lasts exactly one cycle
        a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
            clr_strobe[i] |=> !clr_strobe[i]);
        // R2: a strobe is only issued for a pending bit
        a_r2_strobe_pending: assert property (@(posedge clk) disable iff (!rst_n)
            clr_strobe[i] |-> pend[i]);
        // R2: the pending bit retires after its strobe unless re-requested
        a_r2_pend_retires: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_strobe[i] && !(clr_wr && wr_data[i])) |=> !pend[i]);
        // R1: writing 0 never raises a pending bit
        a_r1_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && !wr_data[i] && !pend[i]) |=> !pend[i]);
        // R6: the target reads zero after its strobe
        a_r6_target_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
            clr_strobe[i] |=> (cnt_all[i] == '0));
    end

    // R4: discharge clear drops its flag and restores its period
    a_r4_dsc_side_effects: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strobe[0] |=> (!flag_all[0] && rate_all[0] == RATE_W'(DEF_RATE)));
    // R5: charge clear drops its flag and restores its period
    a_r5_chg_side_effects: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strobe[1] |=> (!flag_all[1] && rate_all[1] == RATE_W'(DEF_RATE)));
endmodule

bind ccc_top ccc_checker #(
    .NUM_TGT  (NUM_TGT),
    .CNT_W    (CNT_W),
    .RATE_W   (RATE_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .DEF_RATE (DEF_RATE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .clr_strobe (clr_strobe),
    .pend       (pend),
    .cnt_all    (cnt_all),
    .flag_all   (flag_all),
    .rate_all   (rate_all)
);

// File: tb/tb_ccc_top.sv
`timescale 1ns/100ps
// Directed bench for ccc_top: one task per scenario, each checking its results.
module tb_ccc_top;
    localparam int unsigned NUM_EVT = 2;
    localparam int unsigned CNT_W   = 8;
    localparam int unsigned DEF     = 28800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        tb_tick = 1'b0;
    logic [1:0]  time_run = '0;
    logic [1:0]  evt_inc = '0;
    logic [3:0]  clr_strobe;

    int n_chk = 0;
    int n_bad = 0;

    ccc_top #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tb_tick(tb_tick), .time_run(time_run), .evt_inc(evt_inc),
        .clr_strobe(clr_strobe)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = 4'(a);
        #0.1;
        d = int'(rd_data);
    endtask

    task automatic host_write(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Request clears and follow the pending/strobe/zero sequence.
    task automatic do_clear(input int mask, input string tag);
        int v;
        host_write(0, mask);
        rd(0, v); chk({tag, " R1 pending"}, v, mask);
        chk({tag, " R2 no early strobe"}, int'(clr_strobe), 0);
        @(negedge clk);
        chk({tag, " R2 strobe"}, int'(clr_strobe), mask);
        rd(0, v); chk({tag, " R2 pending during strobe"}, v, mask);
        @(negedge clk);
        chk({tag, " R2 strobe single"}, int'(clr_strobe), 0);
        rd(0, v); chk({tag, " R2 self-cleared"}, v, 0);
        for (int i = 0; i < 4; i++) begin
            if (mask[i]) begin
                rd(4 + i, v); chk({tag, " R6 target zero"}, v, 0);
            end
        end
    endtask

    task automatic run_cycles(input logic [1:0] runs, input logic tick, input int n);
        @(negedge clk);
        time_run = runs; tb_tick = tick;
        repeat (n) @(negedge clk);
        time_run = '0; tb_tick = 1'b0;
    endtask

    task automatic t_reset;
        int v;
        rd(0, v); chk("R9 pending", v, 0);
        rd(1, v); chk("R9 dsc period", v, DEF);
        rd(2, v); chk("R9 chg period", v, DEF);
        rd(3, v); chk("R9 flags", v, 0);
        for (int i = 0; i < 4; i++) begin
            rd(4 + i, v); chk("R9 counter", v, 0);
        end
        chk("R9 strobe", int'(clr_strobe), 0);
    endtask

    task automatic t_event_clear;
        int v;
        @(negedge clk); evt_inc = 2'b01;
        repeat (5) @(negedge clk);
        evt_inc = '0;
        rd(6, v); chk("R8 event count", v, 5);
        do_clear(4'b0100, "evt0");
    endtask

    task automatic t_time_count;
        int v;
        host_write(1, 3);
        rd(1, v); chk("R7 period written", v, 3);
        run_cycles(2'b01, 1'b1, 30);
        rd(4, v); chk("R7 period 3 count", v, 10);
        run_cycles(2'b01, 1'b0, 5);
        rd(4, v); chk("R7 no tick no count", v, 10);
        host_write(2, 0);
        run_cycles(2'b10, 1'b1, 7);
        rd(5, v); chk("R7 period 0 acts as 1", v, 7);
    endtask

    task automatic t_wrap(input int idx, input string req);
        int v;
        do_clear(1 << idx, req);
        host_write(1 + idx, 1);
        run_cycles(2'(1 << idx), 1'b1, 255);
        rd(4 + idx, v); chk("R7 count before wrap", v, 255);
        rd(3, v); chk("R7 flag before wrap", v, 0);
        run_cycles(2'(1 << idx), 1'b1, 1);
        rd(4 + idx, v); chk("R7 wrapped to zero", v, 0);
        rd(3, v); chk("R7 wrap flag", v, 1 << idx);
        do_clear(1 << idx, req);
        rd(3, v); chk({req, " flag cleared"}, v, 0);
        rd(1 + idx, v); chk({req, " period restored"}, v, DEF);
    endtask

    task automatic t_multi;
        int v;
        host_write(1, 1);
        host_write(2, 1);
        @(negedge clk);
        evt_inc = 2'b11; time_run = 2'b11; tb_tick = 1'b1;
        repeat (3) @(negedge clk);
        evt_inc = '0; time_run = '0; tb_tick = 1'b0;
        rd(4, v); chk("R3 setup dsc", v, 3);
        rd(7, v); chk("R3 setup evt1", v, 3);
        do_clear(4'b1101, "R3 multi");
        rd(5, v); chk("R3 unselected kept", v, 3);
        rd(2, v); chk("R3 unselected period kept", v, 1);
    endtask

    task automatic t_collide_event;
        int v;
        @(negedge clk); evt_inc = 2'b01;
        host_write(0, 4'b0100);
        @(negedge clk);
        chk("R6 collide strobe", int'(clr_strobe), 4'b0100);
        @(negedge clk);
        evt_inc = '0;
        rd(6, v); chk("R6 clear beats increment", v, 0);
    endtask

    task automatic t_collide_time;
        int v;
        host_write(1, 1);
        @(negedge clk); time_run = 2'b01; tb_tick = 1'b1;
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 16'h0001;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R4 collide strobe", int'(clr_strobe), 1);
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 16'd5;
        @(negedge clk);
        wr_en = 1'b0; time_run = '0; tb_tick = 1'b0;
        rd(4, v); chk("R6 clear beats tick", v, 0);
        rd(1, v); chk("R4 clear beats period write", v, DEF);
    endtask

    task automatic t_ignored;
        int v;
        @(negedge clk); evt_inc = 2'b10;
        repeat (2) @(negedge clk);
        evt_inc = '0;
        host_write(0, 0);
        rd(0, v); chk("R1 zero write no pending", v, 0);
        @(negedge clk);
        chk("R1 zero write no strobe", int'(clr_strobe), 0);
        @(negedge clk);
        rd(7, v); chk("R1 zero write keeps counter", v, 2);
        host_write(3, 16'hFFFF);
        rd(3, v); chk("R10 flags read-only", v, 0);
        host_write(5, 0);
        rd(5, v); chk("R10 counter read-only", v, 3);
        host_write(7, 16'h55);
        rd(7, v); chk("R10 event counter read-only", v, 2);
        rd(0, v); chk("R10 no pending", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event_clear();
        t_time_count();
        t_wrap(0, "R4");
        t_wrap(1, "R5");
        t_multi();
        t_collide_event();
        t_collide_time();
        t_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule